// File: doc/BRIEF.md
# Nibble-Serial Register Port

This block is the slave side of a three-wire serial link that gives a host access to a 16-entry file of 4-bit registers. The wires are a chip select, a shift clock and one bidirectional data line. Each transaction opens when chip select rises. The host then shifts in a 4-bit code that fixes the direction, then a 4-bit start address. After that come any number of data nibbles, one per register. The register address advances after every nibble and rolls over from the top of the file back to entry 0.

The block runs on the system clock. The three serial wires pass through a synchronizer and the shift-clock edges are found by oversampling, so all state stays in a single clock domain. The register file sits outside the block and connects through a combinational read port and a registered write strobe. The block also gives two outputs for the register file. One is a one-cycle pulse raised when a read of the flag register has fully completed, so the register file can clear its interrupt flag. The other is a level that stays high while the block is deselected, so the register file can force its test, reset and read-carry bits to zero.

Top module: `nibble_serial_port`

## Requirements
- R1: Bits travel LSB first in 4-bit groups. The first group after chip select rises is the mode code: 0x3 selects write and 0xC selects read.
- R2: The second group loads the start address. Each later group is data for the current address, and the address steps by one after each data group.
- R3: The address rolls over from 0xF to 0x0 during a burst.
- R4: In write mode, data bits are taken on shift-clock rising edges. Each completed data group gives a single-cycle `rf_we` pulse carrying that group and its address.
- R5: In read mode, `sd_oe` is high during the data phase. Each bit of the addressed register, bit 0 first, is driven on `sd_out` after the shift-clock falling edge that comes before the rising edge at which the host samples it.
- R6: If chip select falls in the middle of a group, that group is discarded. Groups completed earlier in the same transaction keep their effect.
- R7: With any mode code other than 0x3 or 0xC, the rest of the transaction causes no write and `sd_oe` stays low.
- R8: While chip select is low, `sd_oe` is low, and activity on the shift clock and data input causes no write.
- R9: `deselect_clr` is high while chip select is low and low while it is high, after the synchronizer delay.
- R10: `flag_rd` pulses for one cycle only after all four bits of a read of address 0xD have been shifted. A partial read of 0xD or a write to 0xD gives no pulse.
- R11: After chip select falls, the next transaction starts again with a mode code, no matter where the previous one stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select from host, high = selected |
| sck | input | 1 | Shift clock from host, idles low |
| sd_in | input | 1 | Data line as seen from the pad input |
| sd_out | output | 1 | Data driven to the pad in read mode |
| sd_oe | output | 1 | Pad output enable |
| rf_raddr | output | 4 | Register file read address (current address) |
| rf_rdata | input | 4 | Register file read data, combinational from rf_raddr |
| rf_we | output | 1 | Register file write strobe, one cycle |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 4 | Register file write data |
| flag_rd | output | 1 | Pulse: read of the flag register completed |
| deselect_clr | output | 1 | High while the block is deselected |

## Verification
A wrong bit counter shows up at the very next nibble boundary. The host then sees data shifted by one or more bit positions, or a write lands at the wrong address, and this appears within four shift-clock periods. A mode or phase state that is not cleared on deselect corrupts the first nibble of the next transaction: that nibble is treated as an address or as data instead of a mode code. An address counter that steps at the wrong moment moves every later entry of a burst, and this is plainest where the address rolls over from 0xF to 0x0 and at the flag register, where the completion pulse would appear early, late or not at all.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

    localparam int NIB_W = 4;
    localparam int BIT_W = $clog2(NIB_W);

    typedef enum logic [1:0] {
        PH_MODE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        MD_IDLE   = 2'd0,
        MD_WRITE  = 2'd1,
        MD_READ   = 2'd2,
        MD_IGNORE = 2'd3
    } mode_e;

    typedef struct packed {
        phase_e             phase;
        mode_e              mode;
        logic [NIB_W-1:0]   addr;
    } ctrl_st_t;

    function automatic mode_e decode_mode(
        input logic [NIB_W-1:0] code,
        input logic [NIB_W-1:0] wr_code,
        input logic [NIB_W-1:0] rd_code
    );
        if (code == wr_code)      return MD_WRITE;
        else if (code == rd_code) return MD_READ;
        else                      return MD_IGNORE;
    endfunction

endpackage

// File: rtl/nsp_sync.sv
module nsp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_st
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_st[g-1].r;
            end
        end
    end

    assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/nsp_rx.sv
module nsp_rx
    import nsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_s,
    input  logic             rise,
    input  logic             sd_s,
    output logic [BIT_W-1:0] bit_cnt,
    output logic             nib_done,
    output logic [NIB_W-1:0] nib_data
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NIB_W - 1);

    logic [NIB_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            nib_done <= 1'b0;
        end else begin
            nib_done <= 1'b0;
            if (!sel_s) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg[bit_cnt] <= sd_s;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    nib_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign nib_data = shreg;
endmodule

// File: rtl/nsp_ctrl.sv
module nsp_ctrl
    import nsp_pkg::*;
#(
    parameter logic [NIB_W-1:0] WR_CODE   = 4'h3,
    parameter logic [NIB_W-1:0] RD_CODE   = 4'hC,
    parameter logic [NIB_W-1:0] FLAG_ADDR = 4'hD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_s,
    input  logic             nib_done,
    input  logic [NIB_W-1:0] nib_data,
    output ctrl_st_t         st,
    output logic             rf_we,
    output logic [NIB_W-1:0] rf_waddr,
    output logic [NIB_W-1:0] rf_wdata,
    output logic             flag_rd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase <= PH_MODE;
            st.mode  <= MD_IDLE;
            st.addr  <= '0;
            rf_we    <= 1'b0;
            rf_waddr <= '0;
            rf_wdata <= '0;
            flag_rd  <= 1'b0;
        end else begin
            rf_we   <= 1'b0;
            flag_rd <= 1'b0;
            if (nib_done) begin
                case (st.phase)
                    PH_MODE: begin
                        st.mode  <= decode_mode(nib_data, WR_CODE, RD_CODE);
                        st.phase <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        if (st.mode != MD_IGNORE) st.addr <= nib_data;
                        st.phase <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (st.mode == MD_WRITE) begin
                            rf_we    <= 1'b1;
                            rf_waddr <= st.addr;
                            rf_wdata <= nib_data;
                            st.addr  <= st.addr + 1'b1;
                        end else if (st.mode == MD_READ) begin
                            flag_rd  <= (st.addr == FLAG_ADDR);
                            st.addr  <= st.addr + 1'b1;
                        end
                    end
                    default: st.phase <= PH_MODE;
                endcase
            end else if (!sel_s) begin
                st.phase <= PH_MODE;
                st.mode  <= MD_IDLE;
            end
        end
    end
endmodule

// File: rtl/nsp_tx.sv
module nsp_tx
    import nsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_s,
    input  logic             fall,
    input  logic [BIT_W-1:0] bit_cnt,
    input  ctrl_st_t         st,
    input  logic [NIB_W-1:0] rf_rdata,
    output logic             sd_out,
    output logic             oe_q
);
    logic [NIB_W-1:0] shreg;
    logic             active;

    assign active = sel_s && (st.mode == MD_READ) && (st.phase == PH_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            sd_out <= 1'b0;
            oe_q   <= 1'b0;
        end else if (!sel_s) begin
            oe_q   <= 1'b0;
        end else begin
            oe_q <= active;
            if (fall && active) begin
                if (bit_cnt == '0) begin
                    shreg  <= rf_rdata;
                    sd_out <= rf_rdata[0];
                end else begin
                    sd_out <= shreg[bit_cnt];
                end
            end
        end
    end
endmodule

// File: rtl/nibble_serial_port.sv
module nibble_serial_port
    import nsp_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [NIB_W-1:0] WR_CODE     = 4'h3,
    parameter logic [NIB_W-1:0] RD_CODE     = 4'hC,
    parameter logic [NIB_W-1:0] FLAG_ADDR   = 4'hD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             sck,
    input  logic             sd_in,
    output logic             sd_out,
    output logic             sd_oe,
    output logic [NIB_W-1:0] rf_raddr,
    input  logic [NIB_W-1:0] rf_rdata,
    output logic             rf_we,
    output logic [NIB_W-1:0] rf_waddr,
    output logic [NIB_W-1:0] rf_wdata,
    output logic             flag_rd,
    output logic             deselect_clr
);
    logic [2:0]       sync_q;
    logic             sel_s, sck_s, sd_s, sck_d;
    logic             rise, fall;
    logic [BIT_W-1:0] bit_cnt;
    logic             nib_done;
    logic [NIB_W-1:0] nib_data;
    ctrl_st_t         st;
    logic             oe_q;

    nsp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel, sck, sd_in}),
        .q   (sync_q)
    );

    assign {sel_s, sck_s, sd_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    assign rise = sel_s &  sck_s & ~sck_d;
    assign fall = sel_s & ~sck_s &  sck_d;

    nsp_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .sel_s    (sel_s),
        .rise     (rise),
        .sd_s     (sd_s),
        .bit_cnt  (bit_cnt),
        .nib_done (nib_done),
        .nib_data (nib_data)
    );

    nsp_ctrl #(
        .WR_CODE   (WR_CODE),
        .RD_CODE   (RD_CODE),
        .FLAG_ADDR (FLAG_ADDR)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_s    (sel_s),
        .nib_done (nib_done),
        .nib_data (nib_data),
        .st       (st),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .flag_rd  (flag_rd)
    );

    nsp_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .sel_s    (sel_s),
        .fall     (fall),
        .bit_cnt  (bit_cnt),
        .st       (st),
        .rf_rdata (rf_rdata),
        .sd_out   (sd_out),
        .oe_q     (oe_q)
    );

    assign sd_oe        = oe_q & sel;
    assign rf_raddr     = st.addr;
    assign deselect_clr = ~sel_s;
endmodule

// File: rtl/nsp_checker.sv
module nsp_checker
    import nsp_pkg::*;
#(
    parameter logic [NIB_W-1:0] FLAG_ADDR = 4'hD
) (
    input logic             clk,
    input logic             rst,
    input logic             sel,
    input logic             sd_oe,
    input logic             rf_we,
    input logic [NIB_W-1:0] rf_waddr,
    input logic [NIB_W-1:0] rf_raddr,
    input logic             flag_rd
);
    // R8: pad released whenever the host deselects
    assert_hiz_deselected_R8: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !sd_oe);

    // R4: write strobe lasts one cycle
    assert_we_single_R4: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    // R3: address counter has already stepped past the written entry, with roll-over
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_raddr == rf_waddr + 1'b1));

    // R5: no register write while the block drives the pad
    assert_no_write_reading_R5: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> !rf_we);

    // R10: completion pulse is single-cycle
    assert_flag_single_R10: assert property (@(posedge clk) disable iff (rst)
        flag_rd |=> !flag_rd);

    // R10: pulse only once the flag entry has been passed
    assert_flag_addr_R10: assert property (@(posedge clk) disable iff (rst)
        flag_rd |-> (rf_raddr == FLAG_ADDR + 1'b1));
endmodule

bind nibble_serial_port nsp_checker #(.FLAG_ADDR(FLAG_ADDR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .sd_oe    (sd_oe),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_raddr (rf_raddr),
    .flag_rd  (flag_rd)
);

// File: tb/nibble_serial_port_tb.sv
`timescale 1ns/1ps
module nibble_serial_port_tb;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       sck = 1'b0;
    logic       sd_in = 1'b0;
    logic       sd_out, sd_oe, rf_we, flag_rd, deselect_clr;
    logic [3:0] rf_raddr, rf_rdata, rf_waddr, rf_wdata;

    logic [3:0] mem [16];
    int         wr_cnt = 0;
    int         flag_cnt = 0;
    int         oe_cnt = 0;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    nibble_serial_port u_dut (
        .clk(clk), .rst(rst), .sel(sel), .sck(sck), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .flag_rd(flag_rd), .deselect_clr(deselect_clr)
    );

    assign rf_rdata = mem[rf_raddr];

    always @(posedge clk) begin
        if (!rst) begin
            if (rf_we) begin
                mem[rf_waddr] <= rf_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (flag_rd) flag_cnt <= flag_cnt + 1;
            if (sd_oe)   oe_cnt   <= oe_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        sel = 1'b1;
        wait_clk(H);
    endtask

    task automatic sel_off();
        sck = 1'b0;
        wait_clk(4);
        sel = 1'b0;
        wait_clk(H);
    endtask

    task automatic send_nib(input logic [3:0] v);
        for (int i = 0; i < 4; i++) begin
            sd_in = v[i];
            wait_clk(H);
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic send_bits(input logic [3:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sd_in = v[i];
            wait_clk(H);
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic recv_nib(output logic [3:0] v, output logic oe_ok);
        oe_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wait_clk(H);
            v[i] = sd_out;
            if (!sd_oe) oe_ok = 1'b0;
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic write_burst(input logic [3:0] a, input logic [3:0] d0,
                               input logic [3:0] d1, input logic [3:0] d2);
        sel_on();
        send_nib(4'h3);
        send_nib(a);
        send_nib(d0);
        send_nib(d1);
        send_nib(d2);
        sel_off();
    endtask

    task automatic t_reset();
        check("R9 reset deselect_clr", int'(deselect_clr), 1);
        check("R8 reset sd_oe", int'(sd_oe), 0);
        check("R4 reset no write", wr_cnt, 0);
        check("R10 reset no flag", int'(flag_rd), 0);
    endtask

    task automatic t_write();
        int w0;
        w0 = wr_cnt;
        write_burst(4'h5, 4'hA, 4'hB, 4'h6);
        check("R1 write count", wr_cnt - w0, 3);
        check("R2 mem[5]", int'(mem[5]), 'hA);
        check("R2 mem[6]", int'(mem[6]), 'hB);
        check("R4 mem[7]", int'(mem[7]), 'h6);
    endtask

    task automatic t_wrap();
        write_burst(4'hE, 4'h1, 4'h2, 4'h9);
        check("R3 mem[E]", int'(mem[14]), 'h1);
        check("R3 mem[F]", int'(mem[15]), 'h2);
        check("R3 mem[0] after roll", int'(mem[0]), 'h9);
    endtask

    task automatic t_read(input logic [3:0] a, input logic [3:0] e0, input logic [3:0] e1);
        logic [3:0] v;
        logic ok;
        int w0;
        w0 = wr_cnt;
        sel_on();
        send_nib(4'hC);
        send_nib(a);
        recv_nib(v, ok);
        check("R5 read first nibble", int'(v), int'(e0));
        check("R5 sd_oe during read", int'(ok), 1);
        recv_nib(v, ok);
        check("R2 read next nibble", int'(v), int'(e1));
        sel_off();
        check("R5 no write in read", wr_cnt - w0, 0);
        check("R8 sd_oe low after deselect", int'(sd_oe), 0);
    endtask

    task automatic t_partial();
        int w0;
        w0 = wr_cnt;
        sel_on();
        send_nib(4'h3);
        send_nib(4'h2);
        send_nib(4'h9);
        send_bits(4'hF, 2);
        sel_off();
        check("R6 completed nibble kept", int'(mem[2]), 'h9);
        check("R6 partial nibble dropped", wr_cnt - w0, 1);
        check("R6 mem[3] untouched", int'(mem[3]), 'h0);
    endtask

    task automatic t_badmode();
        int w0, o0;
        w0 = wr_cnt;
        o0 = oe_cnt;
        sel_on();
        send_nib(4'h5);
        send_nib(4'h1);
        send_nib(4'hF);
        send_nib(4'hE);
        sel_off();
        check("R7 no write on bad code", wr_cnt - w0, 0);
        check("R7 sd_oe stays low", oe_cnt - o0, 0);
        check("R7 mem[1] unchanged", int'(mem[1]), 'h0);
    endtask

    task automatic t_deselected();
        int w0, o0;
        w0 = wr_cnt;
        o0 = oe_cnt;
        send_nib(4'h3);
        send_nib(4'h4);
        send_nib(4'h7);
        check("R8 no write while deselected", wr_cnt - w0, 0);
        check("R8 sd_oe low while deselected", oe_cnt - o0, 0);
        check("R8 mem[4] unchanged", int'(mem[4]), 'h0);
    endtask

    task automatic t_restart();
        sel_on();
        send_nib(4'h3);
        send_nib(4'h8);
        send_nib(4'h4);
        send_bits(4'h1, 3);
        sel_off();
        write_burst(4'h9, 4'h5, 4'h3, 4'hC);
        check("R11 mem[8] from aborted burst", int'(mem[8]), 'h4);
        check("R11 new burst mem[9]", int'(mem[9]), 'h5);
        check("R11 new burst mem[A]", int'(mem[10]), 'h3);
    endtask

    task automatic t_desel_level();
        sel = 1'b1;
        wait_clk(H);
        check("R9 deselect_clr low when selected", int'(deselect_clr), 0);
        sel = 1'b0;
        wait_clk(H);
        check("R9 deselect_clr high when deselected", int'(deselect_clr), 1);
    endtask

    task automatic t_flag();
        logic [3:0] v;
        logic ok;
        int f0;
        write_burst(4'hC, 4'h2, 4'h7, 4'h1);
        check("R10 no flag on write of D", flag_cnt, 0);
        f0 = flag_cnt;
        sel_on();
        send_nib(4'hC);
        send_nib(4'hC);
        recv_nib(v, ok);
        wait_clk(4);
        check("R10 no flag after reading C", flag_cnt - f0, 0);
        recv_nib(v, ok);
        check("R10 read of D value", int'(v), 'h7);
        wait_clk(4);
        check("R10 flag after full read of D", flag_cnt - f0, 1);
        sel_off();
        f0 = flag_cnt;
        sel_on();
        send_nib(4'hC);
        send_nib(4'hD);
        send_bits(4'h0, 2);
        sel_off();
        check("R10 no flag on partial read of D", flag_cnt - f0, 0);
    endtask

    task automatic run_all();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(H);
        t_reset();
        t_write();
        t_wrap();
        t_read(4'h6, 4'hB, 4'h6);
        t_read(4'hF, 4'h2, 4'h9);
        t_partial();
        t_badmode();
        t_deselected();
        t_restart();
        t_desel_level();
        t_flag();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 4'h0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule